// File: doc/BRIEF.md
# Time-Sliced Saturation Event Counter

This block watches one saturation flag per receive channel while a chirp's sampling window is open. The window is cut into a configured number of back-to-back slices of equal, programmable length. In every slice the block counts the asserted flags of the channels its mask enables, summed over all cycles of that slice. The total is clipped at 255.

Each slice total is written as one 16-bit word through a plain memory write port. The slices are numbered from one: odd slices are primary and even slices are secondary, so with an odd slice count N the words land in order P1, S1, P2, S2, ..., ending on the last primary slice. Successive chirps fill the two halves of the result memory in turn, and a one-cycle pulse marks the end of each chirp's results.

The slice count, slice length and channel mask are captured when the window opens and are held for the whole chirp. A window that closes early still yields N words, and the slices that never ran are written as zero.

Top module: `sat_slice_monitor`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), wr_en and chirp_done are 0, and the first chirp's words are written with wr_addr[7] = 0.
- R2: The word for a slice equals the number of (cycle, channel) pairs inside that slice where win is 1, the channel's sat_flags bit is 1 and its cfg_ch_mask bit is 1.
- R3: A slice word is clipped at 255 and never wraps. A sum of 254 is written unchanged.
- R4: Slice k, counting from 1, is written at wr_addr[6:0] = k-1 with wr_data[15:8] = 0. Odd k is primary and even k is secondary, and each chirp writes exactly cfg_slices words. cfg_slices must be odd, from 1 to 127.
- R5: Slice k covers window cycles (k-1)*L to k*L-1, where L = cfg_slice_len (at least 1) and cycle 0 is the first cycle with win high.
- R6: wr_addr[7] selects the result half. It is the same for every word of one chirp and flips from one chirp to the next.
- R7: If win falls before all slices end, the slice in progress is written with its partial count in the cycle after the first low cycle. Each later slice is then written as zero, one per cycle.
- R8: Flags have no effect outside the window: not after all slices of a chirp have finished while win stays high, and not while win is low between chirps.
- R9: chirp_done is high for exactly one cycle per chirp, in the cycle right after the last word's write.
- R10: cfg_slices, cfg_slice_len and cfg_ch_mask are sampled in the first window cycle. Changing them during a chirp has no effect on that chirp.
- R11: A slice that runs to full length has its word on the write port (wr_en high) in the cycle after the slice's last sampled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock (one flag sample per cycle) |
| rst_n | input | 1 | Synchronous reset, active low |
| sat_flags | input | NUM_CH | One saturation flag per receive channel |
| win | input | 1 | High while the chirp's sampling window is active |
| cfg_slices | input | 7 | Number of slices N (odd, 1 to 127) |
| cfg_slice_len | input | 16 | Slice length in clock cycles (at least 1) |
| cfg_ch_mask | input | NUM_CH | Channels included in the count |
| wr_en | output | 1 | Result word write strobe |
| wr_addr | output | 8 | {half select, slice index} |
| wr_data | output | 16 | Result word, upper byte zero |
| chirp_done | output | 1 | One-cycle pulse after a chirp's last word |

## Verification
The bench aims at the clip point: all channels saturated for long slices must give 255, and a sum of exactly 254 must pass unchanged. A wrapping or early-clipping adder shows up as a wrong byte. Windows that close mid-slice, and exactly on a slice boundary, test the partial-word and zero-fill path. A design that skipped the fill, repeated an index or mistimed the pulse would leave missing or wrong words or a shifted chirp_done. Configuration changes during a chirp, flags held high after the last slice and between chirps, and the alternating half bit catch designs that sample the configuration continuously, leak counts across chirps or fail to toggle the ping-pong half.

// File: rtl/sat_mon_pkg.sv
package sat_mon_pkg;
  localparam int CNT_W   = 8;
  localparam int POP_W   = 6;
  localparam int FLAG_MAX = 32;

  // number of flags set among enabled channels
  function automatic logic [POP_W-1:0] pop_masked(input logic [FLAG_MAX-1:0] f,
                                                  input logic [FLAG_MAX-1:0] m);
    logic [POP_W-1:0] n;
    n = '0;
    for (int i = 0; i < FLAG_MAX; i++) n = n + POP_W'(f[i] & m[i]);
    return n;
  endfunction

  // add an increment, clipping at the count maximum
  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                               input logic [POP_W-1:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + (CNT_W+1)'(b);
    return s[CNT_W] ? {CNT_W{1'b1}} : s[CNT_W-1:0];
  endfunction
endpackage

// File: rtl/sat_slice_accum.sv
module sat_slice_accum
  import sat_mon_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic              restart,
  input  logic              clr,
  input  logic [NUM_CH-1:0] flags,
  input  logic [NUM_CH-1:0] mask,
  output logic [CNT_W-1:0]  sum_now
);
  logic [CNT_W-1:0] acc_q;
  logic [CNT_W-1:0] acc_base;
  logic [POP_W-1:0] inc;

  assign acc_base = restart ? '0 : acc_q;
  assign inc      = sample ? pop_masked(FLAG_MAX'(flags), FLAG_MAX'(mask)) : '0;
  assign sum_now  = sat_add(acc_base, inc);

  always_ff @(posedge clk) begin
    if (!rst_n)      acc_q <= '0;
    else if (clr)    acc_q <= '0;
    else             acc_q <= sum_now;
  end

  // R3: while a slice keeps running the running count never falls (no wrap)
  a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !restart) |=> (acc_q >= $past(acc_q)));

  // R8: without sampling and without restart, the sum equals the held count
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample && !restart && !clr) |=> $stable(acc_q));
endmodule

// File: rtl/sat_slice_seq.sv
module sat_slice_seq
  import sat_mon_pkg::*;
#(
  parameter int IDX_W  = 7,
  parameter int LEN_W  = 16,
  parameter int DATA_W = 16,
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win,
  input  logic [IDX_W-1:0]  cfg_n,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [CNT_W-1:0]  sum_now,
  output logic              sample,
  output logic              restart,
  output logic              clr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              chirp_done
);
  typedef enum logic [2:0] {S_IDLE, S_RUN, S_FILL, S_DONE, S_HOLD} st_t;

  st_t              st_q, st_d;
  logic [IDX_W-1:0] n_q, idx_q, idx_d;
  logic [LEN_W-1:0] len_q, cyc_q, cyc_d;
  logic             half_q;

  logic             idle, start, run_cyc, close_now, fill_now;
  logic [IDX_W-1:0] n_eff, idx_eff;
  logic [LEN_W-1:0] len_eff, cyc_eff;
  logic             slice_end, last_idx, emit;

  assign idle      = (st_q == S_IDLE);
  assign start     = idle && win;
  assign run_cyc   = start || (st_q == S_RUN && win);
  assign close_now = (st_q == S_RUN) && !win;
  assign fill_now  = (st_q == S_FILL);
  assign n_eff     = idle ? cfg_n : n_q;
  assign len_eff   = idle ? ((cfg_len == '0) ? LEN_W'(1) : cfg_len) : len_q;
  assign cyc_eff   = idle ? '0 : cyc_q;
  assign idx_eff   = idle ? '0 : idx_q;
  assign slice_end = run_cyc && (cyc_eff == len_eff - LEN_W'(1));
  assign last_idx  = (idx_eff == n_eff - IDX_W'(1));
  assign emit      = slice_end || close_now || fill_now;

  assign sample  = run_cyc;
  assign restart = start;
  assign clr     = slice_end || close_now;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_eff;
    cyc_d = cyc_eff;
    case (st_q)
      S_IDLE, S_RUN: begin
        if (run_cyc) begin
          st_d = S_RUN;
          if (slice_end) begin
            cyc_d = '0;
            if (last_idx) st_d = S_DONE;
            else          idx_d = idx_eff + IDX_W'(1);
          end else begin
            cyc_d = cyc_eff + LEN_W'(1);
          end
        end else if (close_now) begin
          if (last_idx) st_d = S_DONE;
          else begin
            st_d  = S_FILL;
            idx_d = idx_eff + IDX_W'(1);
          end
        end
      end
      S_FILL: begin
        if (last_idx) st_d = S_DONE;
        else          idx_d = idx_eff + IDX_W'(1);
      end
      S_DONE:  st_d = S_HOLD;
      S_HOLD:  if (!win) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      n_q        <= '0;
      len_q      <= LEN_W'(1);
      idx_q      <= '0;
      cyc_q      <= '0;
      half_q     <= 1'b0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      chirp_done <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      cyc_q <= cyc_d;
      if (start) begin
        n_q   <= n_eff;
        len_q <= len_eff;
      end
      if (st_q == S_DONE) half_q <= ~half_q;
      wr_en      <= emit;
      wr_addr    <= {half_q, idx_eff};
      wr_data    <= fill_now ? '0 : DATA_W'(sum_now);
      chirp_done <= (st_q == S_DONE);
    end
  end

  // R4: upper byte of every stored word is zero
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_data[DATA_W-1:CNT_W] == '0));

  // R4: back-to-back writes step the slice index by one in the same half
  a_r4_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |->
      (wr_addr[IDX_W-1:0] == $past(wr_addr[IDX_W-1:0]) + IDX_W'(1)) &&
      (wr_addr[IDX_W] == $past(wr_addr[IDX_W])));

  // R9: chirp_done follows the write of the last slice and lasts one cycle
  a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    chirp_done |-> ($past(wr_en) && ($past(wr_addr[IDX_W-1:0]) == n_q - IDX_W'(1))));
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    chirp_done |=> !chirp_done);

  // R6: the half select flips together with the end-of-chirp pulse
  a_r6_half_flip: assert property (@(posedge clk) disable iff (!rst_n)
    chirp_done |-> (half_q != $past(half_q)));

  // R10: captured configuration holds for the whole chirp
  a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != S_IDLE && $past(st_q) != S_IDLE) |-> ($stable(n_q) && $stable(len_q)));
endmodule

// File: rtl/sat_slice_monitor.sv
module sat_slice_monitor
  import sat_mon_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int MAX_SLICES = 127,
  parameter int LEN_W      = 16,
  parameter int DATA_W     = 16,
  localparam int IDX_W     = $clog2(MAX_SLICES + 1),
  localparam int ADDR_W    = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] sat_flags,
  input  logic              win,
  input  logic [IDX_W-1:0]  cfg_slices,
  input  logic [LEN_W-1:0]  cfg_slice_len,
  input  logic [NUM_CH-1:0] cfg_ch_mask,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              chirp_done
);
  logic              sample, restart, clr;
  logic [CNT_W-1:0]  sum_now;
  logic [NUM_CH-1:0] mask_q, mask_eff;
  logic              first;

  // mask follows the same capture-at-start rule as the other settings (R10)
  assign first    = restart;
  assign mask_eff = first ? cfg_ch_mask : mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     mask_q <= '0;
    else if (first) mask_q <= cfg_ch_mask;
  end

  sat_slice_accum #(.NUM_CH(NUM_CH)) u_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .sample  (sample),
    .restart (restart),
    .clr     (clr),
    .flags   (sat_flags),
    .mask    (mask_eff),
    .sum_now (sum_now)
  );

  sat_slice_seq #(.IDX_W(IDX_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .win        (win),
    .cfg_n      (cfg_slices),
    .cfg_len    (cfg_slice_len),
    .sum_now    (sum_now),
    .sample     (sample),
    .restart    (restart),
    .clr        (clr),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .chirp_done (chirp_done)
  );

  // R1: nothing is written or signalled in the cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!wr_en && !chirp_done));
endmodule

// File: tb/tb_sat_slice_monitor.sv
`timescale 1ns/1ps
module tb_sat_slice_monitor;
  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] sat_flags = '0;
  logic           win = 1'b0;
  logic [6:0]     cfg_slices = 7'd1;
  logic [15:0]    cfg_slice_len = 16'd1;
  logic [NCH-1:0] cfg_ch_mask = '0;
  logic           wr_en;
  logic [7:0]     wr_addr;
  logic [15:0]    wr_data;
  logic           chirp_done;

  sat_slice_monitor #(.NUM_CH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .sat_flags(sat_flags), .win(win),
    .cfg_slices(cfg_slices), .cfg_slice_len(cfg_slice_len), .cfg_ch_mask(cfg_ch_mask),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .chirp_done(chirp_done)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int tcyc = 0;
  int wcount, dcount, dtime;
  logic [15:0] mem [0:255];
  int wtime [0:255];
  int exp_half = 0;
  bit finished = 0;

  always @(posedge clk) tcyc <= tcyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_en) begin
        mem[wr_addr]   = wr_data;
        wtime[wr_addr] = tcyc;
        wcount++;
      end
      if (chirp_done) begin
        dcount++;
        dtime = tcyc;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  function automatic logic [NCH-1:0] pat(input int sel, input int c);
    case (sel)
      0: return '1;
      1: return NCH'(c ^ (c >> 2));
      2: return '0;
      default: return NCH'(c * 3 + 1);
    endcase
  endfunction

  function automatic int popm(input logic [NCH-1:0] f, input logic [NCH-1:0] m);
    int s = 0;
    for (int i = 0; i < NCH; i++) s += (f[i] & m[i]);
    return s;
  endfunction

  // one chirp: drive window for w cycles, then verify words, timing, half, pulse
  task automatic run_chirp(input int n, input int len, input logic [NCH-1:0] mask,
                           input int w, input int sel, input bit swap_cfg,
                           input string tag);
    int expv [0:127];
    int t0, tw, k, base, et;
    for (int i = 0; i < 128; i++) expv[i] = 0;
    for (int i = 0; i < 256; i++) begin mem[i] = 16'hFFFF; wtime[i] = -1; end
    wcount = 0; dcount = 0; dtime = -1;
    @(negedge clk);
    cfg_slices = 7'(n); cfg_slice_len = 16'(len); cfg_ch_mask = mask;
    win = 1'b1;
    t0 = tcyc;
    for (int c = 0; c < w; c++) begin
      sat_flags = pat(sel, c);
      if (c < n * len) expv[c / len] += popm(sat_flags, mask);
      if (swap_cfg && c == 1) begin
        cfg_slices = 7'd1; cfg_slice_len = 16'd2; cfg_ch_mask = '0;
      end
      @(negedge clk);
    end
    win = 1'b0;
    sat_flags = '1;
    tw = tcyc;
    k = w / len;
    repeat (n + 6) @(negedge clk);
    base = exp_half * 128;
    for (int i = 0; i < n; i++) begin
      if (expv[i] > 255) expv[i] = 255;
      check(mem[base + i] == 16'(expv[i]), {tag, " word"}, int'(mem[base + i]), expv[i]);
      et = ((i + 1) * len <= w) ? t0 + (i + 1) * len : tw + 1 + (i - k);
      check(wtime[base + i] == et, {tag, " R11 write cycle"}, wtime[base + i], et);
    end
    check(wcount == n, "R4 word count", wcount, n);
    check(dcount == 1, "R9 done count", dcount, 1);
    check(dtime == wtime[base + n - 1] + 1, "R9 done cycle", dtime, wtime[base + n - 1] + 1);
    check(mem[(1 - exp_half) * 128] == 16'hFFFF, "R6 other half untouched",
          int'(mem[(1 - exp_half) * 128]), 16'hFFFF);
    exp_half = 1 - exp_half;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(wr_en == 1'b0, "R1 wr_en in reset", wr_en, 0);
    check(chirp_done == 1'b0, "R1 chirp_done in reset", chirp_done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(wr_en == 1'b0 && chirp_done == 1'b0, "R1 quiet after reset", wr_en, 0);
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog all act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    // R1 R2 R5 R8: first chirp in half 0, window outlasts slices
    run_chirp(5, 4, 4'b1111, 30, 1, 0, "R1 R2 R5 R8 basic");
    // R3: clipped sum
    run_chirp(3, 80, 4'b1111, 240, 0, 0, "R3 clip");
    // R3: 254 not clipped
    run_chirp(1, 254, 4'b0001, 254, 0, 0, "R3 no early clip");
    // R2: partial mask, short slices
    run_chirp(7, 3, 4'b0101, 21, 1, 0, "R2 mask");
    // R7: early close mid-slice
    run_chirp(9, 5, 4'b1111, 17, 3, 0, "R7 early mid");
    // R7: early close on a slice boundary
    run_chirp(5, 4, 4'b1011, 8, 3, 0, "R7 early boundary");
    // R10: configuration changed during chirp
    run_chirp(3, 4, 4'b1111, 12, 0, 1, "R10 cfg hold");
    // R4 R6: minimum and maximum slice counts
    run_chirp(1, 1, 4'b1111, 1, 0, 0, "R4 single slice");
    run_chirp(127, 1, 4'b1110, 130, 3, 0, "R4 R6 max slices");
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule